// File: doc/BRIEF.md
# Stochastic Roberts Cross Edge Detector

This block estimates the Roberts cross edge strength of one 2x2 pixel window using stochastic arithmetic rather than binary subtractors and adders. Each pixel value becomes a unipolar bit-stream: a stream generator outputs 1 whenever the pixel value is greater than the current sample of a pseudo-random source. The two pixels on each diagonal share one source, so their streams are fully positively correlated. As a result, a single XOR per diagonal produces a stream whose density equals the absolute difference of the two pixels. A 2:1 multiplexer, driven by a third independent source with a density of one half, averages the two diagonal streams. An up-counter turns the multiplexer output back into a binary value.

A start pulse launches one operation. The stream length is chosen from 8 to 256 cycles, so a caller can trade accuracy for speed. At the end of the stream the block presents the 8-bit result and pulses done. An error-injection path can invert the output stream at a programmable rate, drawn from a fourth independent source, to show how the result degrades under bit flips. All pseudo-random sources are 8-bit maximal-length LFSRs with distinct polynomials. They are reloaded with their seeds on every start, so identical inputs always give identical results.

Top module: `sc_edge_roberts`

## Requirements
- R1: After reset, `result` is 0 and `done` is 0.
- R2: If `start` is high at clock edge k, `done` is high for exactly the one cycle that follows edge k+L, where L is the selected stream length. `result` changes only in a cycle in which `done` is high.
- R3: `len_sel` is sampled at start. Codes 0,1,2,3,4,5 select L = 8,16,32,64,128,256. Codes 6 and 7 select 256.
- R4: With error injection off, a window whose two diagonals hold equal pixel pairs (top-left = bottom-right and top-right = bottom-left) gives a result of 0 at every stream length.
- R5: `result` equals (number of 1s counted) x 256 / L, saturated at 255. For L below 256 it is therefore a multiple of 256/L, or 255.
- R6: For each of a set of test windows at L = 256, `result` is within 40 of the exact value (|tl-br| + |tr-bl|) / 2. The mean absolute error over those windows at L = 256 is at most 16 and is lower than at L = 8.
- R7: The full-scale window (tl=0, br=255, tr=255, bl=0) gives a result of at least 240 at L = 256.
- R8: With `flip_en` = 0 the value of `flip_rate` has no effect. With `flip_en` = 1 and `flip_rate` = 0 no bit is inverted. In both cases the result equals the result with injection off.
- R9: With `flip_en` = 1, a stream bit is inverted when the injection source sample is below `flip_rate`. A rate of 255 on a zero-edge window therefore gives a result of at least 240.
- R10: A low injection rate (`flip_rate` = 13, about 5 %) keeps the L = 256 result within 40 of the exact value.
- R11: A `start` during an operation in progress aborts that operation and restarts from the seeds. No `done` appears for the aborted run, and the result equals the result of an uninterrupted run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle pulse that launches an operation |
| pix_tl | input | 8 | Top-left pixel |
| pix_tr | input | 8 | Top-right pixel |
| pix_bl | input | 8 | Bottom-left pixel |
| pix_br | input | 8 | Bottom-right pixel |
| len_sel | input | 3 | Stream length code |
| flip_en | input | 1 | Enables output bit inversion |
| flip_rate | input | 8 | Inversion threshold, rate of about flip_rate/256 |
| result | output | 8 | Binary edge magnitude |
| done | output | 1 | One-cycle flag marking a new result |

## Verification
The embedded properties check on every cycle that:
- `done` lasts a single cycle and `result` moves only with it;
- the ones count never exceeds the number of elapsed stream cycles;
- no LFSR ever reaches the all-zero state;
- a window with matched diagonals produces a silent stream while injection is off.

Accuracy against the exact Roberts value, the fall in mean error with longer streams, length decoding, and the effect of the injection rate are statistical or end-to-end properties. Only the bench's scenarios can demonstrate them, by comparing finished results against binary arithmetic. The same applies to the abort behaviour on a repeated start.

// File: rtl/sc_edge_pkg.sv
package sc_edge_pkg;
   localparam int unsigned RND_W   = 8;
   localparam int unsigned NUM_SRC = 4;

   typedef enum int unsigned {
      SRC_DIAG_MAIN = 0,
      SRC_DIAG_ANTI = 1,
      SRC_SELECT    = 2,
      SRC_FLIP      = 3
   } src_e;

   // Galois right-shift feedback masks, all maximal length for 8 bits
   function automatic logic [RND_W-1:0] src_mask(input int unsigned idx);
      case (idx)
         0:       return 8'hB8;
         1:       return 8'h8E;
         2:       return 8'h95;
         default: return 8'hB4;
      endcase
   endfunction

   function automatic logic [RND_W-1:0] src_seed(input int unsigned idx);
      case (idx)
         0:       return 8'h5A;
         1:       return 8'hC3;
         2:       return 8'h27;
         default: return 8'h9E;
      endcase
   endfunction
endpackage

// File: rtl/sc_lfsr.sv
module sc_lfsr #(
   parameter int unsigned       W    = 8,
   parameter logic [W-1:0]      MASK = 8'hB8,
   parameter logic [W-1:0]      SEED = 8'h01
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic         step,
   output logic [W-1:0] state
);
   logic [W-1:0] nxt;

   initial begin : elab_chk
      assert (SEED != '0) else $error("sc_lfsr: zero seed locks the register");
      assert (MASK[W-1])  else $error("sc_lfsr: mask must include the top bit");
   end

   always_comb begin
      nxt = {1'b0, state[W-1:1]};
      if (state[0]) nxt = nxt ^ MASK;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    state <= SEED;
      else if (load) state <= SEED;
      else if (step) state <= nxt;
   end

   // a maximal-length register never reaches the lock-up state (accuracy, R6)
   assert_lfsr_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      state != '0);
endmodule

// File: rtl/sc_sng.sv
module sc_sng #(
   parameter int unsigned W = 8
) (
   input  logic [W-1:0] level,
   input  logic [W-1:0] rnd,
   output logic         bit_out
);
   assign bit_out = (level > rnd);
endmodule

// File: rtl/sc_ctr.sv
module sc_ctr #(
   parameter int unsigned CNT_W = 9,
   parameter int unsigned LOG_W = 4,
   parameter int unsigned OUT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [LOG_W-1:0] len_log,
   input  logic             bit_in,
   output logic             busy,
   output logic [OUT_W-1:0] result,
   output logic             done
);
   localparam int unsigned WIDE_W = CNT_W + OUT_W;

   logic [CNT_W-1:0]  cyc_q, cnt_q, cnt_nxt, len_m1;
   logic [LOG_W-1:0]  len_q, shamt;
   logic [WIDE_W-1:0] wide;
   logic [OUT_W-1:0]  scaled;
   logic              last;

   initial begin : elab_chk
      assert ((1 << LOG_W) > OUT_W) else $error("sc_ctr: LOG_W too narrow");
   end

   always_comb begin
      len_m1  = (CNT_W'(1) << len_q) - CNT_W'(1);
      last    = (cyc_q == len_m1);
      cnt_nxt = cnt_q + CNT_W'(bit_in);
      shamt   = LOG_W'(OUT_W) - len_q;
      wide    = WIDE_W'(cnt_nxt) << shamt;
      scaled  = (wide > WIDE_W'({OUT_W{1'b1}})) ? {OUT_W{1'b1}} : wide[OUT_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         cyc_q  <= '0;
         cnt_q  <= '0;
         len_q  <= '0;
         result <= '0;
         done   <= 1'b0;
      end else begin
         done <= 1'b0;
         if (start) begin
            busy  <= 1'b1;
            cyc_q <= '0;
            cnt_q <= '0;
            len_q <= len_log;
         end else if (busy) begin
            cnt_q <= cnt_nxt;
            cyc_q <= cyc_q + CNT_W'(1);
            if (last) begin
               busy   <= 1'b0;
               done   <= 1'b1;
               result <= scaled;
            end
         end
      end
   end

   assert_done_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   assert_result_moves_with_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(result) |-> done);
   assert_count_bounded_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= cyc_q);
endmodule

// File: rtl/sc_edge_roberts.sv
module sc_edge_roberts #(
   parameter int unsigned PIX_W       = 8,
   parameter int unsigned LEN_SEL_W   = 3,
   parameter int unsigned MIN_LEN_LOG = 3,
   parameter int unsigned NUM_LEN     = 6
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic [PIX_W-1:0]     pix_tl,
   input  logic [PIX_W-1:0]     pix_tr,
   input  logic [PIX_W-1:0]     pix_bl,
   input  logic [PIX_W-1:0]     pix_br,
   input  logic [LEN_SEL_W-1:0] len_sel,
   input  logic                 flip_en,
   input  logic [PIX_W-1:0]     flip_rate,
   output logic [PIX_W-1:0]     result,
   output logic                 done
);
   import sc_edge_pkg::*;

   localparam int unsigned MAX_LEN_LOG = MIN_LEN_LOG + NUM_LEN - 1;
   localparam int unsigned CNT_W       = MAX_LEN_LOG + 1;
   localparam int unsigned LOG_W       = $clog2(MAX_LEN_LOG + 1);

   initial begin : elab_chk
      assert (PIX_W == RND_W) else $error("pixel width must match source width");
      assert (MAX_LEN_LOG <= PIX_W) else $error("longest stream exceeds scale");
      assert (NUM_LEN <= (1 << LEN_SEL_W)) else $error("len_sel too narrow");
   end

   logic [RND_W-1:0]     rnd [NUM_SRC];
   logic                 busy;
   logic [LEN_SEL_W-1:0] sel_clamp;
   logic [LOG_W-1:0]     len_log;
   logic                 s_tl, s_br, s_tr, s_bl;
   logic                 diff_main, diff_anti, avg_bit, flip_hit, stream_bit;

   for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
      sc_lfsr #(
         .W   (RND_W),
         .MASK(src_mask(g)),
         .SEED(src_seed(g))
      ) u_lfsr (
         .clk  (clk),
         .rst_n(rst_n),
         .load (start),
         .step (busy),
         .state(rnd[g])
      );
   end

   always_comb begin
      sel_clamp = (len_sel >= LEN_SEL_W'(NUM_LEN)) ? LEN_SEL_W'(NUM_LEN - 1) : len_sel;
      len_log   = LOG_W'(MIN_LEN_LOG) + LOG_W'(sel_clamp);
   end

   // pixels of one diagonal share a source so their XOR is |x - y|
   sc_sng #(.W(PIX_W)) u_sng_tl (.level(pix_tl), .rnd(rnd[SRC_DIAG_MAIN]), .bit_out(s_tl));
   sc_sng #(.W(PIX_W)) u_sng_br (.level(pix_br), .rnd(rnd[SRC_DIAG_MAIN]), .bit_out(s_br));
   sc_sng #(.W(PIX_W)) u_sng_tr (.level(pix_tr), .rnd(rnd[SRC_DIAG_ANTI]), .bit_out(s_tr));
   sc_sng #(.W(PIX_W)) u_sng_bl (.level(pix_bl), .rnd(rnd[SRC_DIAG_ANTI]), .bit_out(s_bl));

   always_comb begin
      diff_main  = s_tl ^ s_br;
      diff_anti  = s_tr ^ s_bl;
      avg_bit    = rnd[SRC_SELECT][RND_W-1] ? diff_anti : diff_main;
      flip_hit   = flip_en && (rnd[SRC_FLIP] < flip_rate);
      stream_bit = avg_bit ^ flip_hit;
   end

   sc_ctr #(
      .CNT_W(CNT_W),
      .LOG_W(LOG_W),
      .OUT_W(PIX_W)
   ) u_ctr (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start),
      .len_log(len_log),
      .bit_in (stream_bit),
      .busy   (busy),
      .result (result),
      .done   (done)
   );

   assert_matched_diagonals_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_tl == pix_br && pix_tr == pix_bl && !flip_en) |-> !stream_bit);
   assert_sources_differ_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rnd[SRC_DIAG_MAIN] != rnd[SRC_DIAG_ANTI] || rnd[SRC_DIAG_MAIN] != rnd[SRC_SELECT]);
endmodule

// File: tb/tb_sc_edge_roberts.sv
module tb_sc_edge_roberts;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic [7:0] pix_tl = '0, pix_tr = '0, pix_bl = '0, pix_br = '0;
   logic [2:0] len_sel = '0;
   logic       flip_en = 1'b0;
   logic [7:0] flip_rate = '0;
   logic [7:0] result;
   logic       done;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 0;

   localparam logic [31:0] WIN [8] = '{
      32'h1080_40F0, 32'hC832_9614, 32'h00FF_00FF, 32'h7F7F_7F7F,
      32'h20A0_6040, 32'hE010_F030, 32'h55AA_33CC, 32'h0102_FEFD
   };

   sc_edge_roberts dut (
      .clk(clk), .rst_n(rst_n), .start(start),
      .pix_tl(pix_tl), .pix_tr(pix_tr), .pix_bl(pix_bl), .pix_br(pix_br),
      .len_sel(len_sel), .flip_en(flip_en), .flip_rate(flip_rate),
      .result(result), .done(done)
   );

   always #10 clk = ~clk;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int absd(input int a, input int b);
      return (a > b) ? a - b : b - a;
   endfunction

   function automatic int exact(input logic [31:0] w);
      return (absd(int'(w[31:24]), int'(w[7:0])) + absd(int'(w[23:16]), int'(w[15:8]))) / 2;
   endfunction

   task automatic set_win(input logic [31:0] w);
      pix_tl = w[31:24]; pix_tr = w[23:16]; pix_bl = w[15:8]; pix_br = w[7:0];
   endtask

   // pulse start, return latency in edges and the result
   task automatic run_op(input logic [31:0] w, input int sel, input bit fen,
                         input int rate, output int res, output int lat);
      set_win(w);
      len_sel = 3'(sel); flip_en = fen; flip_rate = 8'(rate);
      start = 1'b1;
      @(posedge clk); @(negedge clk);
      start = 1'b0;
      lat = 0;
      for (int n = 1; n <= 400; n++) begin
         @(posedge clk); @(negedge clk);
         if (done) begin lat = n; break; end
      end
      res = int'(result);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!finished) begin
         chk(1'b0, "watchdog", 0, 1);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin : main
      int res, lat, res2, lat2;
      int sum_err [6];
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(result == 8'd0, "R1 result", int'(result), 0);
      chk(done == 1'b0, "R1 done", int'(done), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // vector loop: accuracy and latency per length (R2, R3, R5, R6)
      for (int s = 0; s < 6; s++) sum_err[s] = 0;
      for (int i = 0; i < 8; i++) begin
         for (int s = 0; s < 6; s++) begin
            run_op(WIN[i], s, 1'b0, 0, res, lat);
            chk(lat == (8 << s), "R2 R3 latency", lat, 8 << s);
            if (s < 5)
               chk((res % (32 >> s)) == 0 || res == 255, "R5 granularity", res, (res / (32 >> s)) * (32 >> s));
            sum_err[s] += absd(res, exact(WIN[i]));
            if (s == 5) chk(absd(res, exact(WIN[i])) <= 40, "R6 window error", res, exact(WIN[i]));
         end
      end
      chk(sum_err[5] <= 16 * 8, "R6 mean error at 256", sum_err[5], 16 * 8);
      chk(sum_err[5] < sum_err[0], "R6 error falls with length", sum_err[5], sum_err[0]);

      // R3 codes 6 and 7 clamp to 256
      run_op(WIN[0], 6, 1'b0, 0, res, lat);
      chk(lat == 256, "R3 code 6", lat, 256);
      run_op(WIN[0], 7, 1'b0, 0, res2, lat);
      chk(lat == 256, "R3 code 7", lat, 256);
      chk(res == res2, "R3 codes 6 and 7 agree", res2, res);

      // R4 matched diagonals
      run_op(32'h6425_2564, 0, 1'b0, 0, res, lat);
      chk(res == 0, "R4 zero at 8", res, 0);
      run_op(32'h6425_2564, 5, 1'b0, 0, res, lat);
      chk(res == 0, "R4 zero at 256", res, 0);

      // R7 full scale
      run_op(32'h00FF_00FF, 5, 1'b0, 0, res, lat);
      chk(res >= 240, "R7 full scale", res, 240);

      // R8 injection neutral cases
      run_op(WIN[4], 5, 1'b0, 0, res, lat);
      run_op(WIN[4], 5, 1'b1, 0, res2, lat);
      chk(res2 == res, "R8 rate zero", res2, res);
      run_op(WIN[4], 5, 1'b0, 200, res2, lat);
      chk(res2 == res, "R8 disabled ignores rate", res2, res);

      // R9 near-total inversion
      run_op(32'h3030_3030, 5, 1'b1, 255, res, lat);
      chk(res >= 240, "R9 full inversion", res, 240);

      // R10 low injection rate
      run_op(WIN[4], 5, 1'b1, 13, res, lat);
      chk(absd(res, exact(WIN[4])) <= 40, "R10 5 percent flips", res, exact(WIN[4]));

      // R11 restart mid-run
      run_op(WIN[1], 2, 1'b0, 0, res, lat);
      set_win(WIN[1]); len_sel = 3'd2; flip_en = 1'b0;
      start = 1'b1; @(posedge clk); @(negedge clk); start = 1'b0;
      lat2 = 0;
      for (int n = 0; n < 10; n++) begin
         @(posedge clk); @(negedge clk);
         if (done) lat2 = 1;
      end
      chk(lat2 == 0, "R11 no early done", lat2, 0);
      run_op(WIN[1], 2, 1'b0, 0, res2, lat);
      chk(lat == 32, "R11 restart latency", lat, 32);
      chk(res2 == res, "R11 restart result", res2, res);

      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule